// File: doc/BRIEF.md
# Boot and Reset Output Controller

This block takes a device from power-on reset to normal operation. Once the asynchronous power-on reset is released, it writes zero into every location of the register file, one location per cycle. It then copies a window of configuration words from a synchronous nonvolatile read port into the register file, in ascending address order. While these two phases run, the block blocks serial register access, masks every fault source and keeps the general-purpose output drivers disabled. At the end it raises a one-cycle boot-done pulse.

After boot, the active-low reset output stays low until two conditions hold on the same clock edge: the supply sequencer reports completion, and every monitored channel is in range. Only then does a programmable hold-off count start. If either condition drops during the count, the count is discarded. A drop after release pulls the reset output low again.

While the configuration word is copied, the block snoops one bit of it. That bit decides whether the watchdog enable comes up as soon as boot ends, or only once the sequencer has completed.

Top module: `boot_rst_ctrl`

## Requirements
- R1: While `por_n` is low: `rst_n_out`=0, `gpio_oe`=0, `host_block`=1, `fault_mask`=1, `boot_done`=0 and `wdog_en`=0.
- R2: Clear phase. Starting in the cycle in which `por_n` rises, and for 2^RF_AW consecutive cycles, `rf_we`=1 and `rf_wdata`=0. `rf_addr` takes each value 0, 1, 2, … in ascending order.
- R3: Copy phase. Right after the clear phase, for k = 0 to COPY_WORDS-1 in ascending order, one read per cycle: `nv_rd_en`=1 with `nv_addr`=NV_BASE+k. In the following cycle, `rf_we`=1, `rf_addr`=k and `rf_wdata` equals `nv_rdata` (read latency is one cycle). With the defaults, storage address 0x273 lands at register 0x73.
- R4: `boot_done` is high for exactly one cycle, the cycle after the last copy write. That is cycle 2^RF_AW + COPY_WORDS + 1 counted from the release of `por_n`, and it must fall below BOOT_LIMIT cycles.
- R5: `host_block` and `fault_mask` are 1 and `gpio_oe` is 0 from reset until the cycle in which `boot_done` pulses. From that cycle on, the values are inverted.
- R6: `rst_n_out` stays 0 during boot. After boot it stays 0 while `seq_done` and `chan_ok` are not both 1 on the same edge.
- R7: Take the first post-boot edge E at which `seq_done`=`chan_ok`=1. If both stay 1, `rst_n_out` rises after edge E+`tmo_cycles`+1.
- R8: If either `seq_done` or `chan_ok` is 0 at an edge during the hold-off count, the count is discarded and `rst_n_out` stays 0. A full new hold-off is needed once both return to 1.
- R9: While `rst_n_out` is 1, an edge with `seq_done` or `chan_ok` at 0 drives `rst_n_out` to 0 after that edge. Release then follows R7 again.
- R10: Bit 4 of the word written to register 0x73 during copy selects the watchdog mode. If the bit is 1, `wdog_en` is 1 from the `boot_done` cycle on. If it is 0, `wdog_en` rises after the first post-boot edge with `seq_done`=1. In both modes, `wdog_en` then stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| nv_rd_en | output | 1 | Nonvolatile read strobe |
| nv_addr | output | NV_AW | Nonvolatile read address |
| nv_rdata | input | DW | Read data, valid one cycle after the strobe |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | RF_AW | Register-file write address |
| rf_wdata | output | DW | Register-file write data |
| seq_done | input | 1 | Supply sequencing complete |
| chan_ok | input | 1 | All channels inside their thresholds |
| tmo_cycles | input | TMO_W | Reset hold-off length in cycles |
| host_block | output | 1 | Serial register access blocked |
| fault_mask | output | 1 | All fault sources masked |
| gpio_oe | output | 1 | General-purpose output drivers enabled |
| boot_done | output | 1 | One-cycle pulse at the end of boot |
| wdog_en | output | 1 | Watchdog enable |
| rst_n_out | output | 1 | Active-low system reset output |

## Verification
The hardest states to reach are the ones after boot: a drop of a channel inside the hold-off window, and the two watchdog modes. Each needs the full clear-and-copy sequence to have finished, and the mode also depends on one bit of a stored word. The bench boots twice, once with bit 4 of the word at storage 0x273 set and once with it clear. After the first boot it places one-cycle drops of `chan_ok` and `seq_done` at chosen points of the count and after release. A cycle-accurate reference model checks every output on every clock throughout.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;
    typedef enum logic [1:0] {CP_CLEAR, CP_COPY, CP_LAST, CP_DONE} cp_phase_e;
    typedef enum logic [1:0] {RL_WAIT, RL_COUNT, RL_RUN} rl_phase_e;
endpackage

// File: rtl/brc_copy_engine.sv
`timescale 1ns/1ps
module brc_copy_engine
    import brc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int RF_AW      = 7,
    parameter int NV_AW      = 10,
    parameter int NV_BASE    = 512,
    parameter int COPY_WORDS = 128,
    parameter int CFG_ADDR   = 'h73,
    parameter int WD_BIT     = 4,
    parameter int BOOT_LIMIT = 7500
) (
    input  logic             clk,
    input  logic             por_n,
    output logic             nv_rd_en,
    output logic [NV_AW-1:0] nv_addr,
    input  logic [DW-1:0]    nv_rdata,
    output logic             rf_we,
    output logic [RF_AW-1:0] rf_addr,
    output logic [DW-1:0]    rf_wdata,
    output logic             busy,
    output logic             boot_done,
    output logic             wd_indep
);
    localparam int RF_DEPTH = 1 << RF_AW;
    localparam logic [RF_AW-1:0] CLR_LAST = RF_AW'(RF_DEPTH - 1);
    localparam logic [RF_AW-1:0] CPY_LAST = RF_AW'(COPY_WORDS - 1);
    localparam logic [RF_AW-1:0] CFG_IDX  = RF_AW'(CFG_ADDR);
    localparam int BC_W = $clog2(BOOT_LIMIT + 1);
    localparam logic [BC_W-1:0] BOOT_LIM_V = BC_W'(BOOT_LIMIT);

    typedef struct packed {
        cp_phase_e        phase;
        logic [RF_AW-1:0] idx;
        logic             pend;
        logic [RF_AW-1:0] paddr;
        logic             indep;
        logic             done;
    } cp_state_t;

    localparam cp_state_t CP_RST = '{CP_CLEAR, '0, 1'b0, '0, 1'b0, 1'b0};

    cp_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.pend = 1'b0;
        s_d.done = 1'b0;
        if (s_q.pend && (s_q.paddr == CFG_IDX)) begin
            s_d.indep = nv_rdata[WD_BIT];
        end
        case (s_q.phase)
            CP_CLEAR: begin
                if (s_q.idx == CLR_LAST) begin
                    s_d.phase = CP_COPY;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            CP_COPY: begin
                s_d.pend  = 1'b1;
                s_d.paddr = s_q.idx;
                if (s_q.idx == CPY_LAST) begin
                    s_d.phase = CP_LAST;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            CP_LAST: begin
                s_d.phase = CP_DONE;
                s_d.done  = 1'b1;
            end
            default: s_d.phase = CP_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= CP_RST;
        else        s_q <= s_d;
    end

    assign nv_rd_en  = (s_q.phase == CP_COPY);
    assign nv_addr   = NV_AW'(NV_BASE) + NV_AW'(s_q.idx);
    assign rf_we     = (s_q.phase == CP_CLEAR) || s_q.pend;
    assign rf_addr   = (s_q.phase == CP_CLEAR) ? s_q.idx : s_q.paddr;
    assign rf_wdata  = s_q.pend ? nv_rdata : '0;
    assign busy      = (s_q.phase != CP_DONE);
    assign boot_done = s_q.done;
    assign wd_indep  = s_q.indep;

    // boot-length guard, used only by the checks below
    logic [BC_W-1:0] boot_cyc_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                           boot_cyc_q <= '0;
        else if (busy && boot_cyc_q != BOOT_LIM_V) boot_cyc_q <= boot_cyc_q + 1'b1;
    end

    AST_CLEAR_ASCEND: assert property (@(posedge clk) disable iff (!por_n)
        (s_q.phase == CP_CLEAR && s_q.idx != CLR_LAST) |=> (rf_we && rf_addr == $past(rf_addr) + 1'b1 && rf_wdata == '0)); // R2
    AST_READ_ASCEND: assert property (@(posedge clk) disable iff (!por_n)
        (nv_rd_en && s_q.idx != CPY_LAST) |=> (nv_rd_en && nv_addr == $past(nv_addr) + 1'b1)); // R3
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!por_n)
        nv_rd_en |=> (rf_we && rf_addr == RF_AW'($past(nv_addr) - NV_AW'(NV_BASE)) && rf_wdata == nv_rdata)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        boot_done |=> !boot_done); // R4
    AST_BOOT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        busy |-> (boot_cyc_q < BOOT_LIM_V)); // R4
endmodule

// File: rtl/brc_release_timer.sv
`timescale 1ns/1ps
module brc_release_timer
    import brc_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ready,
    input  logic             seq_done,
    input  logic             chan_ok,
    input  logic [TMO_W-1:0] tmo_cycles,
    output logic             rst_n_out
);
    typedef struct packed {
        rl_phase_e        phase;
        logic [TMO_W-1:0] cnt;
    } rl_state_t;

    localparam rl_state_t RL_RST = '{RL_WAIT, '0};

    rl_state_t s_q, s_d;
    logic      both_ok;

    always_comb begin
        both_ok = seq_done && chan_ok;
        s_d     = s_q;
        case (s_q.phase)
            RL_WAIT: begin
                if (ready && both_ok) begin
                    s_d.phase = RL_COUNT;
                    s_d.cnt   = '0;
                end
            end
            RL_COUNT: begin
                if (!both_ok) begin
                    s_d.phase = RL_WAIT;
                    s_d.cnt   = '0;
                end else if (s_q.cnt >= tmo_cycles) begin
                    s_d.phase = RL_RUN;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RL_RUN: begin
                if (!both_ok) s_d.phase = RL_WAIT;
            end
            default: s_d = RL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= RL_RST;
        else        s_q <= s_d;
    end

    assign rst_n_out = (s_q.phase == RL_RUN);

    AST_NO_RELEASE_IN_BOOT: assert property (@(posedge clk) disable iff (!por_n)
        !ready |-> !rst_n_out); // R6
    AST_RELEASE_NEEDS_OK: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_out) |-> $past(seq_done && chan_ok)); // R7
    AST_DROP_RESTARTS: assert property (@(posedge clk) disable iff (!por_n)
        (s_q.phase == RL_COUNT && !both_ok) |=> (!rst_n_out && s_q.cnt == '0)); // R8
    AST_DROP_REASSERT: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n_out && !both_ok) |=> !rst_n_out); // R9
endmodule

// File: rtl/boot_rst_ctrl.sv
`timescale 1ns/1ps
module boot_rst_ctrl #(
    parameter int DW         = 8,
    parameter int RF_AW      = 7,
    parameter int NV_AW      = 10,
    parameter int NV_BASE    = 512,
    parameter int COPY_WORDS = 128,
    parameter int CFG_ADDR   = 'h73,
    parameter int WD_BIT     = 4,
    parameter int TMO_W      = 16,
    parameter int BOOT_LIMIT = 7500
) (
    input  logic             clk,
    input  logic             por_n,
    output logic             nv_rd_en,
    output logic [NV_AW-1:0] nv_addr,
    input  logic [DW-1:0]    nv_rdata,
    output logic             rf_we,
    output logic [RF_AW-1:0] rf_addr,
    output logic [DW-1:0]    rf_wdata,
    input  logic             seq_done,
    input  logic             chan_ok,
    input  logic [TMO_W-1:0] tmo_cycles,
    output logic             host_block,
    output logic             fault_mask,
    output logic             gpio_oe,
    output logic             boot_done,
    output logic             wdog_en,
    output logic             rst_n_out
);
    logic busy;
    logic wd_indep;

    typedef struct packed {
        logic seen;
    } top_state_t;

    top_state_t t_q, t_d;

    brc_copy_engine #(
        .DW(DW), .RF_AW(RF_AW), .NV_AW(NV_AW), .NV_BASE(NV_BASE),
        .COPY_WORDS(COPY_WORDS), .CFG_ADDR(CFG_ADDR), .WD_BIT(WD_BIT),
        .BOOT_LIMIT(BOOT_LIMIT)
    ) u_copy (
        .clk(clk), .por_n(por_n),
        .nv_rd_en(nv_rd_en), .nv_addr(nv_addr), .nv_rdata(nv_rdata),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .busy(busy), .boot_done(boot_done), .wd_indep(wd_indep)
    );

    brc_release_timer #(.TMO_W(TMO_W)) u_rel (
        .clk(clk), .por_n(por_n), .ready(!busy),
        .seq_done(seq_done), .chan_ok(chan_ok), .tmo_cycles(tmo_cycles),
        .rst_n_out(rst_n_out)
    );

    always_comb begin
        t_d      = t_q;
        t_d.seen = t_q.seen || (!busy && seq_done);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign host_block = busy;
    assign fault_mask = busy;
    assign gpio_oe    = !busy;
    assign wdog_en    = !busy && (wd_indep || t_q.seen);

    AST_GATES_OPEN_AT_DONE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(host_block) |-> boot_done); // R5
    AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        wdog_en |=> wdog_en); // R10
    AST_WDOG_AFTER_BOOT: assert property (@(posedge clk) disable iff (!por_n)
        wdog_en |-> !host_block); // R10
    AST_RST_AFTER_BOOT: assert property (@(posedge clk) disable iff (!por_n)
        rst_n_out |-> gpio_oe); // R6
endmodule

// File: tb/boot_rst_ctrl_test.sv
`timescale 1ns/1ps
module boot_rst_ctrl_test;
    localparam int DW = 8, RF_AW = 7, NV_AW = 10, NV_BASE = 512;
    localparam int COPY_WORDS = 128, TMO_W = 16;
    localparam int RF_DEPTH = 1 << RF_AW;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic nv_rd_en;
    logic [NV_AW-1:0] nv_addr;
    logic [DW-1:0] nv_rdata = '0;
    logic rf_we;
    logic [RF_AW-1:0] rf_addr;
    logic [DW-1:0] rf_wdata;
    logic seq_done = 1'b0, chan_ok = 1'b0;
    logic [TMO_W-1:0] tmo_cycles = 16'd5;
    logic host_block, fault_mask, gpio_oe, boot_done, wdog_en, rst_n_out;
    logic [7:0] cfg_word = 8'h13;

    int errors = 0, checks = 0;
    bit finished = 0;
    string cur_req = "R6";
    int cyc_idx = 0, done_at = -1, word73 = -1;

    // reference model state
    int m_ph, m_idx, m_pend, m_paddr, m_cnt, m_indep, m_seen, m_done;

    boot_rst_ctrl uut (
        .clk(clk), .por_n(por_n), .nv_rd_en(nv_rd_en), .nv_addr(nv_addr),
        .nv_rdata(nv_rdata), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .seq_done(seq_done), .chan_ok(chan_ok), .tmo_cycles(tmo_cycles),
        .host_block(host_block), .fault_mask(fault_mask), .gpio_oe(gpio_oe),
        .boot_done(boot_done), .wdog_en(wdog_en), .rst_n_out(rst_n_out)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] nvf(input int a);
        int t;
        if (a == NV_BASE + 'h73) return cfg_word;
        t = a * 37 + 5;
        return t[7:0];
    endfunction

    always @(posedge clk) if (nv_rd_en) nv_rdata <= nvf(int'(nv_addr));

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc_idx);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_idx = 0; m_pend = 0; m_paddr = 0; m_cnt = 0;
        m_indep = 0; m_seen = 0; m_done = 0; cyc_idx = 0; done_at = -1; word73 = -1;
    endtask

    task automatic model_step();
        int both;
        both = (seq_done && chan_ok) ? 1 : 0;
        if (m_pend != 0 && m_paddr == 'h73) m_indep = cfg_word[4] ? 1 : 0;
        if (m_ph >= 3 && seq_done) m_seen = 1;
        m_done = (m_ph == 2) ? 1 : 0;
        m_pend = 0;
        case (m_ph)
            0: if (m_idx == RF_DEPTH - 1) begin m_ph = 1; m_idx = 0; end else m_idx++;
            1: begin
                m_pend = 1; m_paddr = m_idx;
                if (m_idx == COPY_WORDS - 1) begin m_ph = 2; m_idx = 0; end else m_idx++;
            end
            2: m_ph = 3;
            3: if (both != 0) begin m_ph = 4; m_cnt = 0; end
            4: if (both == 0) begin m_ph = 3; m_cnt = 0; end
               else if (m_cnt >= int'(tmo_cycles)) m_ph = 5;
               else m_cnt++;
            default: if (both == 0) m_ph = 3;
        endcase
    endtask

    task automatic compare_all();
        string cp;
        int busy;
        cp = (m_ph == 0) ? "R2" : "R3";
        busy = (m_ph < 3) ? 1 : 0;
        check(cp, "rf_we", int'(rf_we), (m_ph == 0 || m_pend != 0) ? 1 : 0);
        if (rf_we) begin
            check(cp, "rf_addr", int'(rf_addr), (m_ph == 0) ? m_idx : m_paddr);
            check(cp, "rf_wdata", int'(rf_wdata), (m_pend != 0) ? int'(nvf(NV_BASE + m_paddr)) : 0);
        end
        check("R3", "nv_rd_en", int'(nv_rd_en), (m_ph == 1) ? 1 : 0);
        if (nv_rd_en) check("R3", "nv_addr", int'(nv_addr), NV_BASE + m_idx);
        check("R4", "boot_done", int'(boot_done), m_done);
        check("R5", "host_block", int'(host_block), busy);
        check("R5", "fault_mask", int'(fault_mask), busy);
        check("R5", "gpio_oe", int'(gpio_oe), 1 - busy);
        check((busy != 0) ? "R6" : cur_req, "rst_n_out", int'(rst_n_out), (m_ph == 5) ? 1 : 0);
        check("R10", "wdog_en", int'(wdog_en), (busy == 0 && (m_indep != 0 || m_seen != 0)) ? 1 : 0);
        if (boot_done && done_at < 0) done_at = cyc_idx;
        if (rf_we && rf_addr == 7'h73 && cyc_idx >= RF_DEPTH) word73 = int'(rf_wdata);
    endtask

    task automatic cyc();
        #1;
        compare_all();
        model_step();
        cyc_idx++;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic check_reset_state();
        #1;
        check("R1", "rst_n_out", int'(rst_n_out), 0);
        check("R1", "gpio_oe", int'(gpio_oe), 0);
        check("R1", "host_block", int'(host_block), 1);
        check("R1", "fault_mask", int'(fault_mask), 1);
        check("R1", "boot_done", int'(boot_done), 0);
        check("R1", "wdog_en", int'(wdog_en), 0);
    endtask

    task automatic do_boot();
        por_n = 1'b1;
        while (done_at < 0 && cyc_idx < 2000) cyc();
        check("R4", "boot cycles", done_at, RF_DEPTH + COPY_WORDS + 1);
        check("R3", "word at 0x73", word73, int'(cfg_word));
    endtask

    initial begin
        // first boot: watchdog independent (bit 4 set)
        model_reset();
        repeat (3) @(negedge clk);
        check_reset_state();
        @(negedge clk);
        do_boot();
        #1 check("R10", "wdog_en indep after boot", int'(wdog_en), 1);
        check("R5", "gpio_oe after boot", int'(gpio_oe), 1);
        cur_req = "R6";
        seq_done = 1; chan_ok = 0; run(8);
        seq_done = 0; chan_ok = 1; run(5);
        #1 check("R6", "rst held without both", int'(rst_n_out), 0);
        cur_req = "R7";
        seq_done = 1; chan_ok = 1; run(4);
        cur_req = "R8";
        chan_ok = 0; run(2);
        chan_ok = 1; run(5);
        #1 check("R8", "rst held after restart", int'(rst_n_out), 0);
        cur_req = "R7";
        run(10);
        #1 check("R7", "rst released", int'(rst_n_out), 1);
        cur_req = "R9";
        seq_done = 0; run(1);
        #1 check("R9", "rst reasserted", int'(rst_n_out), 0);
        seq_done = 1; run(12);
        cur_req = "R7";
        tmo_cycles = 0; chan_ok = 0; run(1);
        chan_ok = 1; run(1);
        #1 check("R7", "zero timeout still counting", int'(rst_n_out), 0);
        run(1);
        #1 check("R7", "zero timeout released", int'(rst_n_out), 1);
        run(3);

        // second boot: watchdog follows sequencer (bit 4 clear)
        por_n = 0; cfg_word = 8'h03; model_reset();
        check_reset_state();
        @(negedge clk);
        seq_done = 0; chan_ok = 1; tmo_cycles = 2;
        @(negedge clk);
        do_boot();
        cur_req = "R6";
        run(6);
        #1 check("R10", "wdog_en waits for sequencer", int'(wdog_en), 0);
        cur_req = "R7";
        seq_done = 1; run(6);
        #1 check("R10", "wdog_en after sequencer", int'(wdog_en), 1);
        check("R7", "rst released mode 2", int'(rst_n_out), 1);
        cur_req = "R9";
        seq_done = 0; run(3);
        #1 check("R10", "wdog_en sticky", int'(wdog_en), 1);
        check("R9", "rst low after drop", int'(rst_n_out), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule